// File: doc/BRIEF.md
# Sleep and Wake-up Reset Controller

This block decides when a small 8-bit processor core powers down and what brings it back. A one-cycle strobe from the core's sleep instruction stops the clock oscillator. The block then waits for one of three enabled events: an external reset on the shared reset pin, a watchdog time-out, or a change on a monitored input pin. Every wake-up is a full core reset that lasts a fixed number of cycles. The core does not resume where it stopped.

Three status flags record the cause of the last reset, so that start-up code can tell a power-on from a wake-up and find which event caused it. Pin-change wake-up does not compare the pins with their value at sleep entry. It compares them with a reference captured at the most recent port access. So if software did not read the port before sleeping, a stale reference wakes the core on the very next cycle.

The monitored pins pass through a synchronizer before they are compared. A watchdog-caused reset stays inside the chip: the block has no output that drives the external reset pin.

Top module: `swc_ctrl`

## Requirements
- R1: While the core is awake and not in reset, a sleep strobe with no reset event in the same cycle has these effects from the next cycle on: the oscillator enable is low, the power-down flag (status bit 3) is 0 and the time-out flag (status bit 4) is 1.
- R2: The monitored pins pass through SYNC_STAGES flip-flops before any comparison. A port-access strobe while awake loads the synchronized pin value as the change reference. The reference is zero after power-on reset.
- R3: An active-low external reset request wakes the core only when the shared pin is configured as a reset input. While the pin is not configured as a reset, the request is ignored and the core stays asleep.
- R4: A watchdog time-out wakes the core only when the watchdog enable is high. A time-out while the watchdog is disabled leaves the core asleep.
- R5: While wake-on-change is enabled, a wake-up happens when the synchronized pins differ from the reference. If they already differ at sleep entry, the wake-up comes one cycle after entry. While wake-on-change is disabled, pin changes are ignored.
- R6: On every wake-up, the oscillator enable returns high, the watchdog-clear output pulses for one cycle, and the core reset request stays high for RST_LEN cycles. All three start in the cycle after the event. Sleep entry also pulses the watchdog-clear output for one cycle.
- R7: A reset caused by the watchdog clears the time-out flag, whether the core was asleep or awake. The power-down flag is set only by power-on reset and cleared only by sleep entry. Wake-ups and time-outs while awake leave it unchanged.
- R8: The pin-change flag is set by a pin-change wake-up. It then holds its value until power-on reset.
- R9: A sleep strobe is ignored while the core reset request is high, and also when a reset event occurs in the same cycle.
- R10: After power-on reset, the oscillator enable and both the time-out and power-down flags are 1. The watchdog clear, core reset request and pin-change flag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| sleep_req_i | input | 1 | Sleep instruction strobe |
| ext_rst_n_i | input | 1 | External reset request, active low |
| ext_rst_cfg_i | input | 1 | Shared pin configured as reset input |
| wdt_en_i | input | 1 | Watchdog enabled |
| wdt_timeout_i | input | 1 | Watchdog time-out pulse |
| woc_en_i | input | 1 | Wake-on-change enable |
| pins_i | input | NPIN | Monitored input pins |
| port_access_i | input | 1 | Port read or read-modify-write strobe |
| osc_en_o | output | 1 | Oscillator enable |
| wdt_clr_o | output | 1 | Watchdog clear pulse |
| core_rst_o | output | 1 | Core reset request |
| flag_to_o | output | 1 | Time-out flag |
| flag_pd_o | output | 1 | Power-down flag |
| flag_wuf_o | output | 1 | Pin-change wake flag |

## Verification
The bench builds the block with NPIN=3, SYNC_STAGES=2 and RST_LEN=3. A three-cycle reset window is short enough to land a sleep strobe inside it and check that the strobe is refused. Two synchronizer stages make the pin-to-wake latency a visible two cycles, so a block that compares the raw pins would miss by a cycle. Three pins allow references and changes that differ in one bit or in several bits.

// File: rtl/swc_pkg.sv
package swc_pkg;

    // Control state kept in the controller.
    typedef struct packed {
        logic asleep;   // oscillator stopped
        logic clr;      // watchdog clear pulse
        logic to;       // time-out flag
        logic pd;       // power-down flag
        logic wuf;      // pin-change wake flag
    } swc_core_t;

    localparam swc_core_t SWC_POR = '{asleep: 1'b0, clr: 1'b0, to: 1'b1, pd: 1'b1, wuf: 1'b0};

endpackage

// File: rtl/swc_sync.sv
module swc_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    generate
        if (STAGES <= 1) begin : g_single
            logic [W-1:0] sh_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q <= '0;
                else        sh_q <= d_i;
            end
            assign q_o = sh_q;
        end else begin : g_chain
            localparam int SW = STAGES * W;
            logic [SW-1:0] sh_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q <= '0;
                else        sh_q <= {sh_q[SW-W-1:0], d_i};
            end
            assign q_o = sh_q[SW-1 -: W];
        end
    endgenerate
endmodule

// File: rtl/swc_rst_stretch.sv
module swc_rst_stretch #(
    parameter int LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    output logic active_o
);
    localparam int CW = $clog2(LEN + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (fire_i)              cnt_d = CW'(LEN);
        else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign active_o = (cnt_q != '0);

    // R6
    held_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && !fire_i && cnt_q > CW'(1)) |=> active_o);
endmodule

// File: rtl/swc_ctrl.sv
module swc_ctrl #(
    parameter int NPIN        = 3,
    parameter int SYNC_STAGES = 2,
    parameter int RST_LEN     = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sleep_req_i,
    input  logic            ext_rst_n_i,
    input  logic            ext_rst_cfg_i,
    input  logic            wdt_en_i,
    input  logic            wdt_timeout_i,
    input  logic            woc_en_i,
    input  logic [NPIN-1:0] pins_i,
    input  logic            port_access_i,
    output logic            osc_en_o,
    output logic            wdt_clr_o,
    output logic            core_rst_o,
    output logic            flag_to_o,
    output logic            flag_pd_o,
    output logic            flag_wuf_o
);
    import swc_pkg::*;

    typedef struct packed {
        swc_core_t       c;
        logic [NPIN-1:0] refv;
    } swc_state_t;

    swc_state_t st_d, st_q;
    logic [NPIN-1:0] pins_s;
    logic ev_ext, ev_wdt, ev_chg, ev_any, fire;

    swc_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(pins_i), .q_o(pins_s)
    );

    swc_rst_stretch #(.LEN(RST_LEN)) u_stretch (
        .clk(clk), .rst_n(rst_n), .fire_i(fire), .active_o(core_rst_o)
    );

    always_comb begin
        ev_ext = ext_rst_cfg_i && !ext_rst_n_i;
        ev_wdt = wdt_en_i && wdt_timeout_i;
        ev_chg = st_q.c.asleep && woc_en_i && (pins_s != st_q.refv);
        ev_any = ev_ext || ev_wdt || ev_chg;
        fire   = 1'b0;

        st_d       = st_q;
        st_d.c.clr = 1'b0;

        if (st_q.c.asleep) begin
            if (ev_any) begin
                fire          = 1'b1;
                st_d.c.asleep = 1'b0;
                st_d.c.clr    = 1'b1;
                if (ev_wdt) st_d.c.to  = 1'b0;
                if (ev_chg) st_d.c.wuf = 1'b1;
            end
        end else begin
            if (ev_ext || ev_wdt) begin
                fire = 1'b1;
                if (ev_wdt) st_d.c.to = 1'b0;
            end else if (sleep_req_i && !core_rst_o) begin
                st_d.c.asleep = 1'b1;
                st_d.c.clr    = 1'b1;
                st_d.c.to     = 1'b1;
                st_d.c.pd     = 1'b0;
            end
            if (port_access_i) st_d.refv = pins_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.c    <= SWC_POR;
            st_q.refv <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign osc_en_o   = !st_q.c.asleep;
    assign wdt_clr_o  = st_q.c.clr;
    assign flag_to_o  = st_q.c.to;
    assign flag_pd_o  = st_q.c.pd;
    assign flag_wuf_o = st_q.c.wuf;

    // R1
    sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_en_o && sleep_req_i && !core_rst_o && !ev_ext && !ev_wdt)
        |=> (!osc_en_o && !flag_pd_o && flag_to_o && wdt_clr_o));

    // R6
    wake_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_en_o && ev_any) |=> (osc_en_o && core_rst_o && wdt_clr_o));

    // R4
    stay_asleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_en_o && !ev_any) |=> !osc_en_o);

    // R7
    pd_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_pd_o |=> !flag_pd_o);

    // R8
    wuf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_wuf_o |=> flag_wuf_o);

    // R9
    no_sleep_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_en_o && core_rst_o) |=> osc_en_o);
endmodule

// File: tb/tb_swc_ctrl.sv
module tb_swc_ctrl;
    localparam int NPIN = 3;
    localparam int SYNC = 2;
    localparam int RLEN = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_req = 1'b0, ext_rst_n = 1'b1, ext_cfg = 1'b1;
    logic wdt_en = 1'b1, wdt_tmo = 1'b0, woc_en = 1'b1, port_acc = 1'b0;
    logic [NPIN-1:0] pins = '0;
    logic osc_en, wdt_clr, core_rst, f_to, f_pd, f_wuf;

    always #2 clk = ~clk;   // 250 MHz

    swc_ctrl #(.NPIN(NPIN), .SYNC_STAGES(SYNC), .RST_LEN(RLEN)) dut (
        .clk(clk), .rst_n(rst_n), .sleep_req_i(sleep_req), .ext_rst_n_i(ext_rst_n),
        .ext_rst_cfg_i(ext_cfg), .wdt_en_i(wdt_en), .wdt_timeout_i(wdt_tmo),
        .woc_en_i(woc_en), .pins_i(pins), .port_access_i(port_acc),
        .osc_en_o(osc_en), .wdt_clr_o(wdt_clr), .core_rst_o(core_rst),
        .flag_to_o(f_to), .flag_pd_o(f_pd), .flag_wuf_o(f_wuf)
    );

    // Behavioural reference model
    int checks = 0, failures = 0, cycles = 0;
    string phase = "R10";
    bit m_asleep = 0, m_clr = 0, m_to = 1, m_pd = 1, m_wuf = 0;
    int m_ref = 0, m_rcnt = 0;
    int hist[$];
    bit done = 0;

    initial for (int i = 0; i < SYNC; i++) hist.push_back(0);

    always @(posedge clk) begin
        int seen;
        bit e_ext, e_wdt, e_chg, go;
        seen = hist[0];
        if (!rst_n) begin
            m_asleep = 0; m_clr = 0; m_to = 1; m_pd = 1; m_wuf = 0; m_ref = 0; m_rcnt = 0;
            hist.delete();
            for (int i = 0; i < SYNC; i++) hist.push_back(0);
        end else begin
            e_ext = ext_cfg && !ext_rst_n;
            e_wdt = wdt_en && wdt_tmo;
            e_chg = m_asleep && woc_en && (seen != m_ref);
            go = 0;
            m_clr = 0;
            if (m_asleep) begin
                if (e_ext || e_wdt || e_chg) begin
                    go = 1; m_asleep = 0; m_clr = 1;
                    if (e_wdt) m_to = 0;
                    if (e_chg) m_wuf = 1;
                end
            end else begin
                if (e_ext || e_wdt) begin
                    go = 1;
                    if (e_wdt) m_to = 0;
                end else if (sleep_req && m_rcnt == 0) begin
                    m_asleep = 1; m_clr = 1; m_to = 1; m_pd = 0;
                end
                if (port_acc) m_ref = seen;
            end
            if (go) m_rcnt = RLEN;
            else if (m_rcnt > 0) m_rcnt--;
            void'(hist.pop_front());
            hist.push_back(int'(pins));
        end
    end

    task automatic chk(string what, bit act, bit exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", phase, what, act, exp, $time);
        end
    endtask

    // Compare on every falling edge
    always @(negedge clk) if (!done) begin
        chk("osc_en (R1,R6)", osc_en, !m_asleep);
        chk("wdt_clr (R6)", wdt_clr, m_clr);
        chk("core_rst (R6)", core_rst, m_rcnt != 0);
        chk("flag_to (R7)", f_to, m_to);
        chk("flag_pd (R7)", f_pd, m_pd);
        chk("flag_wuf (R8)", f_wuf, m_wuf);
    end

    task automatic tick(int n);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic pulse_sleep();
        sleep_req = 1; tick(1); sleep_req = 0;
    endtask

    task automatic access();
        port_acc = 1; tick(1); port_acc = 0;
    endtask

    task automatic wake_state(string what, bit exp_awake);
        checks++;
        if (osc_en !== exp_awake) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b", phase, what, osc_en, exp_awake);
        end
    endtask

    initial begin
        tick(3);
        // R10: reset values are checked by the per-cycle compare
        rst_n = 1; tick(2);

        // R2, R5: reference from synced pins, then wake on a single-bit change
        phase = "R2"; pins = 3'b101; tick(3); access(); tick(1);
        phase = "R5"; pulse_sleep(); tick(4);
        wake_state("asleep with pins equal to reference", 0);
        pins = 3'b100; tick(8);
        wake_state("awake after pin change", 1);

        // R4: disabled watchdog time-out ignored, enabled one wakes
        phase = "R4"; access(); tick(1); pulse_sleep(); tick(2);
        wdt_en = 0; wdt_tmo = 1; tick(1); wdt_tmo = 0; tick(2);
        wake_state("disabled time-out ignored", 0);
        wdt_en = 1; wdt_tmo = 1; tick(1); wdt_tmo = 0; tick(6);

        // R3: external reset ignored when unconfigured
        phase = "R3"; ext_cfg = 0; pulse_sleep(); tick(1);
        ext_rst_n = 0; tick(2); ext_rst_n = 1; tick(1);
        wake_state("unconfigured external reset ignored", 0);
        ext_cfg = 1; ext_rst_n = 0; tick(1); ext_rst_n = 1; tick(6);

        // R5: stale reference gives an immediate wake-up
        phase = "R5"; pins = 3'b011; tick(3); pulse_sleep(); tick(6);
        // R5: wake-on-change disabled
        access(); woc_en = 0; pulse_sleep(); pins = 3'b000; tick(5);
        wake_state("disabled wake-on-change ignored", 0);
        woc_en = 1; tick(6);

        // R7: time-out while awake clears to, leaves pd
        phase = "R7"; access(); tick(1); wdt_tmo = 1; tick(1); wdt_tmo = 0;
        // R9: sleep strobe during core reset ignored
        phase = "R9"; pulse_sleep(); tick(5);
        sleep_req = 1; ext_rst_n = 0; tick(1); sleep_req = 0; ext_rst_n = 1; tick(5);
        // R1: ordinary sleep entry, woken by time-out
        phase = "R1"; pulse_sleep(); tick(3);
        wdt_tmo = 1; tick(1); wdt_tmo = 0; tick(5);
        // R8: a fresh power-on reset clears the pin-change flag
        phase = "R8"; rst_n = 0; tick(2); rst_n = 1; tick(3);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            checks++; failures++;
            $display("FAIL watchdog run did not finish actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule